// File: doc/BRIEF.md
# Double-Buffered Channel Address Sequencer

This block tracks buffer addresses for one streaming data channel using a pair of buffers. Software loads a pending ("next") buffer by writing its first and last quadlet addresses, then raises a ready flag. The sequencer moves the pending bounds into the active ("current") registers and clears the ready flag in the same step. It also posts a buffer-start event, so software can queue the following buffer while the active one drains.

A data mover reads the active quadlet address. It pulses an acknowledge once for each 32-bit word it transfers, whether sending or receiving. The sequencer steps the address by four bytes on each pulse. When the word at the inclusive end address is acknowledged, it posts a buffer-done event. A packet-oriented buffer follows the same rule: done comes only after the final word of the last packet, however many packets the buffer holds.

If no pending buffer is queued when the active one finishes, the channel stops and posts an error event. Status bits are cleared by writing a one to them. A single interrupt line combines the status bits that software has enabled.

Top module: `chan_addr_seq`

## Requirements
- R1: After reset, status, ready, busy and irq are all 0, and the current and next address registers are 0.
- R2: Promotion happens when ready is set and the channel is either idle or accepting its last quadlet. On that clock edge, cur_addr takes the next start, cur_end takes the next end, ready clears, busy goes to 1, and status bit 3 (start) sets.
- R3: Writes to the next start or end register take effect only while ready is 0. While ready is 1 they are ignored.
- R4: While busy, each quad_ack that is not on the last quadlet adds 4 to cur_addr. While idle, quad_ack leaves cur_addr unchanged.
- R5: Status bit 2 (done) sets on the edge where quad_ack is accepted with cur_addr equal to cur_end. The end address is inclusive.
- R6: If ready is set when the last quadlet is accepted, the next buffer is promoted on that same edge, and busy stays 1 with no idle cycle.
- R7: If ready is clear when the last quadlet is accepted, busy drops to 0 and status bit 1 (error) sets. A later ready starts a new buffer from idle.
- R8: Status bits clear when a one is written to them through stat_clr_we/stat_clr_mask. A hardware set on the same edge wins over the clear. Status bit 0 always reads 0.
- R9: irq is high exactly when some status bit is set and its matching bit in irq_en is set.
- R10: A buffer whose start equals its end is done after exactly one quad_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_start_we | input | 1 | Write nxt_addr_wd to the next start register |
| nxt_end_we | input | 1 | Write nxt_addr_wd to the next end register |
| nxt_addr_wd | input | AW | Address write data |
| rdy_set | input | 1 | Mark the next buffer ready |
| stat_clr_we | input | 1 | Apply the write-1-to-clear mask |
| stat_clr_mask | input | 4 | Status bits to clear |
| irq_en | input | 4 | Interrupt enable per status bit |
| quad_ack | input | 1 | Data mover accepted the current quadlet |
| cur_addr | output | AW | Address of the quadlet in progress |
| cur_end | output | AW | Last quadlet address of the current buffer |
| nxt_start | output | AW | Queued start address |
| nxt_end | output | AW | Queued end address |
| rdy | output | 1 | Next buffer queued |
| busy | output | 1 | A current buffer is active |
| status | output | 4 | bit3 start, bit2 done, bit1 error, bit0 zero |
| irq | output | 1 | Interrupt request |

## Verification
A wrong address step or a missed end compare shows up one clock later. It appears either as a wrong cur_addr or as a done bit that does not set, and a run that never ends keeps busy high past the expected drain point. A promotion bug shows on the same edge: ready fails to clear, or the current bounds differ from the queued ones. A status priority error is exposed by clearing a bit on the very edge that sets it. The bench compares every output against its reference model on every clock, so a divergence is reported within one cycle of its cause.

// File: rtl/chseq_pkg.sv
package chseq_pkg;

    localparam int STAT_W     = 4;
    localparam int ST_ERR     = 1;
    localparam int ST_DONE    = 2;
    localparam int ST_START   = 3;
    localparam int QUAD_BYTES = 4;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_e;

    typedef struct packed {
        logic start;
        logic done;
        logic err;
    } stat_evt_t;

    function automatic logic [STAT_W-1:0] evt_to_bits(stat_evt_t e);
        logic [STAT_W-1:0] b;
        b           = '0;
        b[ST_START] = e.start;
        b[ST_DONE]  = e.done;
        b[ST_ERR]   = e.err;
        return b;
    endfunction

endpackage

// File: rtl/chseq_next_buf.sv
module chseq_next_buf #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_start,
    input  logic          wr_end,
    input  logic [AW-1:0] wr_addr,
    input  logic          rdy_set,
    input  logic          promote,
    output logic [AW-1:0] nxt_start,
    output logic [AW-1:0] nxt_end,
    output logic          rdy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_start <= '0;
            nxt_end   <= '0;
            rdy       <= 1'b0;
        end else begin
            // a queued buffer is frozen until hardware takes it
            if (!rdy) begin
                if (wr_start) nxt_start <= wr_addr;
                if (wr_end)   nxt_end   <= wr_addr;
            end
            if (promote)
                rdy <= 1'b0;
            else if (rdy_set)
                rdy <= 1'b1;
        end
    end

endmodule

// File: rtl/chseq_walker.sv
module chseq_walker
    import chseq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          quad_ack,
    input  logic          rdy,
    input  logic [AW-1:0] nxt_start,
    input  logic [AW-1:0] nxt_end,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_end,
    output logic          busy,
    output logic          promote,
    output stat_evt_t     evt
);

    localparam logic [AW-1:0] STEP = AW'(QUAD_BYTES);

    walk_e state;
    logic  last_quad;

    assign busy      = (state == WALK_RUN);
    assign last_quad = busy && quad_ack && (cur_addr == cur_end);
    assign promote   = rdy && (!busy || last_quad);

    always_comb begin
        evt.start = promote;
        evt.done  = last_quad;
        evt.err   = last_quad && !rdy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WALK_IDLE;
            cur_addr <= '0;
            cur_end  <= '0;
        end else if (promote) begin
            state    <= WALK_RUN;
            cur_addr <= nxt_start;
            cur_end  <= nxt_end;
        end else if (last_quad) begin
            state    <= WALK_IDLE;
        end else if (busy && quad_ack) begin
            cur_addr <= cur_addr + STEP;
        end
    end

endmodule

// File: rtl/chseq_status.sv
module chseq_status
    import chseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stat_evt_t         evt,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic [STAT_W-1:0] irq_en,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] clr_bits;

    assign set_bits = evt_to_bits(evt);
    assign clr_bits = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (status & ~clr_bits) | set_bits;
    end

    assign irq = |(status & irq_en);

endmodule

// File: rtl/chan_addr_seq.sv
module chan_addr_seq
    import chseq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nxt_start_we,
    input  logic              nxt_end_we,
    input  logic [AW-1:0]     nxt_addr_wd,
    input  logic              rdy_set,
    input  logic              stat_clr_we,
    input  logic [STAT_W-1:0] stat_clr_mask,
    input  logic [STAT_W-1:0] irq_en,
    input  logic              quad_ack,
    output logic [AW-1:0]     cur_addr,
    output logic [AW-1:0]     cur_end,
    output logic [AW-1:0]     nxt_start,
    output logic [AW-1:0]     nxt_end,
    output logic              rdy,
    output logic              busy,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic      promote;
    stat_evt_t evt;

    chseq_next_buf #(.AW(AW)) u_next (
        .clk       (clk),
        .rst       (rst),
        .wr_start  (nxt_start_we),
        .wr_end    (nxt_end_we),
        .wr_addr   (nxt_addr_wd),
        .rdy_set   (rdy_set),
        .promote   (promote),
        .nxt_start (nxt_start),
        .nxt_end   (nxt_end),
        .rdy       (rdy)
    );

    chseq_walker #(.AW(AW)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .quad_ack  (quad_ack),
        .rdy       (rdy),
        .nxt_start (nxt_start),
        .nxt_end   (nxt_end),
        .cur_addr  (cur_addr),
        .cur_end   (cur_end),
        .busy      (busy),
        .promote   (promote),
        .evt       (evt)
    );

    chseq_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_we   (stat_clr_we),
        .clr_mask (stat_clr_mask),
        .irq_en   (irq_en),
        .status   (status),
        .irq      (irq)
    );

endmodule

// File: rtl/chan_addr_seq_chk.sv
module chan_addr_seq_chk
    import chseq_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              nxt_start_we,
    input logic              nxt_end_we,
    input logic              quad_ack,
    input logic [STAT_W-1:0] stat_clr_mask,
    input logic              stat_clr_we,
    input logic [STAT_W-1:0] irq_en,
    input logic [AW-1:0]     cur_addr,
    input logic [AW-1:0]     cur_end,
    input logic [AW-1:0]     nxt_start,
    input logic [AW-1:0]     nxt_end,
    input logic              rdy,
    input logic              busy,
    input logic [STAT_W-1:0] status,
    input logic              irq
);

    logic at_last;
    assign at_last = busy && quad_ack && (cur_addr == cur_end);

    p_promote_r2: assert property (@(posedge clk) disable iff (rst)
        rdy && (!busy || at_last) |=>
            cur_addr == $past(nxt_start) && cur_end == $past(nxt_end)
            && !rdy && busy && status[ST_START]);

    p_next_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        rdy && (nxt_start_we || nxt_end_we) |=>
            nxt_start == $past(nxt_start) && nxt_end == $past(nxt_end));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        busy && quad_ack && cur_addr != cur_end |=>
            cur_addr == $past(cur_addr) + AW'(QUAD_BYTES));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !busy && !rdy |=> $stable(cur_addr));

    p_done_r5: assert property (@(posedge clk) disable iff (rst)
        at_last |=> status[ST_DONE]);

    p_no_gap_r6: assert property (@(posedge clk) disable iff (rst)
        at_last && rdy |=> busy);

    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        at_last && !rdy |=> !busy && status[ST_ERR]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        at_last && stat_clr_we && stat_clr_mask[ST_DONE] |=> status[ST_DONE]);

    p_bit0_r8: assert property (@(posedge clk) disable iff (rst)
        status[0] == 1'b0);

    p_irq_r9: assert property (@(posedge clk) disable iff (rst)
        irq == (|(status & irq_en)));

endmodule

bind chan_addr_seq chan_addr_seq_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .nxt_start_we  (nxt_start_we),
    .nxt_end_we    (nxt_end_we),
    .quad_ack      (quad_ack),
    .stat_clr_mask (stat_clr_mask),
    .stat_clr_we   (stat_clr_we),
    .irq_en        (irq_en),
    .cur_addr      (cur_addr),
    .cur_end       (cur_end),
    .nxt_start     (nxt_start),
    .nxt_end       (nxt_end),
    .rdy           (rdy),
    .busy          (busy),
    .status        (status),
    .irq           (irq)
);

// File: tb/sim_chan_addr_seq.sv
module sim_chan_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          nxt_start_we = 1'b0;
    logic          nxt_end_we = 1'b0;
    logic [AW-1:0] nxt_addr_wd = '0;
    logic          rdy_set = 1'b0;
    logic          stat_clr_we = 1'b0;
    logic [3:0]    stat_clr_mask = '0;
    logic [3:0]    irq_en = '0;
    logic          quad_ack = 1'b0;
    logic [AW-1:0] cur_addr, cur_end, nxt_start, nxt_end;
    logic          rdy, busy, irq;
    logic [3:0]    status;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // reference model state
    logic [AW-1:0] m_cur, m_end, m_ns, m_ne;
    logic          m_rdy, m_busy;
    logic [3:0]    m_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_addr_seq #(.AW(AW)) u0 (
        .clk(clk), .rst(rst),
        .nxt_start_we(nxt_start_we), .nxt_end_we(nxt_end_we),
        .nxt_addr_wd(nxt_addr_wd), .rdy_set(rdy_set),
        .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
        .irq_en(irq_en), .quad_ack(quad_ack),
        .cur_addr(cur_addr), .cur_end(cur_end),
        .nxt_start(nxt_start), .nxt_end(nxt_end),
        .rdy(rdy), .busy(busy), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step();
        bit lastq, prom;
        logic [3:0] nstat;
        if (rst) begin
            m_cur = '0; m_end = '0; m_ns = '0; m_ne = '0;
            m_rdy = 0; m_busy = 0; m_stat = '0;
            return;
        end
        lastq = m_busy && quad_ack && (m_cur == m_end);
        prom  = m_rdy && (!m_busy || lastq);
        nstat = m_stat;
        if (stat_clr_we) nstat = nstat & ~stat_clr_mask;
        if (prom)  nstat[3] = 1'b1;
        if (lastq) nstat[2] = 1'b1;
        if (lastq && !m_rdy) nstat[1] = 1'b1;
        if (prom) begin
            m_cur = m_ns; m_end = m_ne; m_busy = 1;
        end else if (lastq) begin
            m_busy = 0;
        end else if (m_busy && quad_ack) begin
            m_cur = m_cur + 4;
        end
        if (!m_rdy) begin
            if (nxt_start_we) m_ns = nxt_addr_wd;
            if (nxt_end_we)   m_ne = nxt_addr_wd;
        end
        if (prom) m_rdy = 0;
        else if (rdy_set) m_rdy = 1;
        m_stat = nstat;
    endtask

    task automatic compare_all();
        chk(cur_addr == m_cur, "R4 cur_addr", cur_addr, m_cur);
        chk(cur_end == m_end, "R2 cur_end", cur_end, m_end);
        chk(nxt_start == m_ns && nxt_end == m_ne, "R3 next regs", nxt_start, m_ns);
        chk(rdy == m_rdy, "R2 rdy", AW'(rdy), AW'(m_rdy));
        chk(busy == m_busy, "R6 busy", AW'(busy), AW'(m_busy));
        chk(status == m_stat, "R8 status", AW'(status), AW'(m_stat));
        chk(irq == |(m_stat & irq_en), "R9 irq", AW'(irq), AW'(|(m_stat & irq_en)));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        nxt_start_we = 0; nxt_end_we = 0; rdy_set = 0;
        stat_clr_we = 0; stat_clr_mask = '0; quad_ack = 0;
    endtask

    task automatic queue_buf(input logic [AW-1:0] s, input logic [AW-1:0] e);
        nxt_start_we = 1; nxt_addr_wd = s; tick();
        nxt_end_we = 1;   nxt_addr_wd = e; tick();
        rdy_set = 1; tick();
    endtask

    task automatic acks(input int n);
        for (int i = 0; i < n; i++) begin
            quad_ack = 1; tick();
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1;
        tick(); tick(); tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(status == 4'h0 && !rdy && !busy && !irq, "R1 reset flags",
            {status, rdy, busy, irq}, '0);
        chk(cur_addr == '0 && nxt_start == '0, "R1 reset addresses", cur_addr, '0);

        // R4: ack while idle is ignored
        acks(2);
        chk(cur_addr == '0 && !busy, "R4 idle ack ignored", cur_addr, '0);

        // buffer A 0x100..0x10C : promoted on the rdy_set edge's following edge
        queue_buf(32'h100, 32'h10C);
        tick();
        chk(cur_addr == 32'h100 && cur_end == 32'h10C, "R2 promote copy", cur_addr, 32'h100);
        chk(status[3] == 1 && !rdy && busy, "R2 start bit and rdy clear", AW'(status), 32'h8);

        // queue B while A runs; then attempt overwrite while ready
        queue_buf(32'h200, 32'h204);
        nxt_start_we = 1; nxt_addr_wd = 32'hDEAD_0000; tick();
        nxt_end_we = 1;   nxt_addr_wd = 32'hDEAD_0004; tick();
        chk(nxt_start == 32'h200 && nxt_end == 32'h204, "R3 write ignored while ready",
            nxt_start, 32'h200);

        // walk A: three steps then last ack with simultaneous done clear
        quad_ack = 1; tick();
        chk(cur_addr == 32'h104, "R4 step by 4", cur_addr, 32'h104);
        tick();
        acks(2);
        chk(cur_addr == 32'h10C, "R4 reach end", cur_addr, 32'h10C);
        quad_ack = 1; stat_clr_we = 1; stat_clr_mask = 4'b0100; tick();
        chk(status[2] == 1, "R5 done on last quadlet", AW'(status), 32'h4);
        chk(status[2] == 1, "R8 set beats clear", AW'(status[2]), 1);
        chk(busy && cur_addr == 32'h200 && !rdy, "R6 back-to-back promote", cur_addr, 32'h200);

        // R8 write-1-to-clear
        stat_clr_we = 1; stat_clr_mask = 4'b1111; tick();
        chk(status == 4'h0, "R8 w1c clears all", AW'(status), 0);

        // B has two quadlets, nothing queued -> stall
        acks(1);
        chk(status[2] == 0 && busy, "R5 no early done", AW'(status), 0);
        acks(1);
        chk(!busy && status[1] && status[2], "R7 stall sets error", AW'(status), 32'h6);
        acks(1);
        chk(cur_addr == 32'h204, "R7 idle after stall", cur_addr, 32'h204);

        // R9 interrupt enables
        irq_en = 4'b0010; tick();
        chk(irq == 1, "R9 irq enabled bit", AW'(irq), 1);
        irq_en = 4'b0001; tick();
        chk(irq == 0, "R9 irq masked", AW'(irq), 0);
        stat_clr_we = 1; stat_clr_mask = 4'b1110; tick();

        // R10 single quadlet buffer resumes from idle (R7)
        queue_buf(32'h300, 32'h300);
        tick();
        chk(busy && cur_addr == 32'h300, "R7 resume after stall", cur_addr, 32'h300);
        acks(1);
        chk(status[2] == 1 && !busy, "R10 single quadlet done", AW'(status), 32'hC);

        // pseudo-random mix compared cycle by cycle against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            quad_ack     = lfsr[0] | lfsr[5];
            nxt_start_we = lfsr[1] & lfsr[2];
            nxt_end_we   = lfsr[3] & lfsr[4];
            nxt_addr_wd  = {16'h0, lfsr[9:6], 4'h0, 4'h0, 4'h0} + (lfsr[6] ? 32'h10 : 32'h0);
            rdy_set      = lfsr[7] & lfsr[8];
            stat_clr_we  = lfsr[11];
            stat_clr_mask = lfsr[15:12];
            irq_en       = lfsr[3:0];
            tick();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule